// File: doc/BRIEF.md
# Digital Window PLL Lock Detector

This block judges whether a phase-locked loop has settled. It runs on a fast sampling clock and receives single-cycle pulses that mark each phase-detector reference edge and each divided-VCO edge. Every reference pulse opens a timing window. A divided-VCO pulse that falls inside the window is a hit. A VCO pulse outside the window is a miss. A reference edge that receives no VCO pulse is also a miss.

A run of consecutive hits, whose length is programmable, raises the lock flag. Any single miss drops the flag at once and restarts the run. The window comes from one of two sources. It can be a level supplied from outside. It can also be built internally as a power-of-two timer base multiplied by a programmable count.

The lock flag is always visible on a status output. It is also routed to a shared pin that otherwise carries serial read data.

Top module: `pll_lock_win_det`

## Requirements
- R1: While rst_ni is low, and in the first cycle after its release, lock_o and stat_o are 0.
- R2: cnt_sel_i = n needs 2^(n+6) consecutive hits: n = 0 needs 64, n = 5 needs 2048, n = 7 needs 8192. lock_o rises on the clock edge that registers the final hit of the run.
- R3: With win_sel_i = 1 the window opens in the cycle of the ref_pulse_i pulse. It stays open for (tmr_mult_i + 1) * 2^(tmr_sel_i + 2) cycles, counting that cycle. A vco_pulse_i in any open cycle is a hit.
- R4: A vco_pulse_i while the window is closed is a miss. lock_o is 0 from the next edge on, and the run count restarts.
- R5: A missing arrival is a miss. In digital mode this means the window closes without a vco_pulse_i. In either mode it means a new ref_pulse_i comes, without a coincident vco_pulse_i, while the previous reference is still unanswered.
- R6: After a miss, lock_o stays 0 until a full new run of the required length is complete.
- R7: With win_sel_i = 0 the window is the level on ext_win_i. A vco_pulse_i with ext_win_i = 1 is a hit, and with ext_win_i = 0 it is a miss.
- R8: stat_o always equals lock_o.
- R9: When pin_sel_i = 1, pin_en_i = 1 and pin_hold_i = 1, pin_o carries lock_o, even during a read.
- R10: When pin_sel_i = 1, pin_en_i = 1 and pin_hold_i = 0, pin_o carries lock_o while rd_active_i = 0 and sdo_i while rd_active_i = 1.
- R11: When pin_sel_i differs from 1, or pin_en_i = 0, pin_o carries sdo_i.
- R12: Hits beyond the required run keep lock_o high. The run count saturates and does not wrap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Sampling clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ref_pulse_i | input | 1 | Reference edge pulse, one cycle |
| vco_pulse_i | input | 1 | Divided-VCO edge pulse, one cycle |
| win_sel_i | input | 1 | Window source: 0 external level, 1 internal timer |
| ext_win_i | input | 1 | External window level |
| tmr_sel_i | input | 2 | Timer base: 2^(tmr_sel_i+2) cycles |
| tmr_mult_i | input | 3 | Window length in timer periods, minus one |
| cnt_sel_i | input | 3 | Required run: 2^(cnt_sel_i+6) hits |
| pin_sel_i | input | 5 | Shared pin source select; code 1 chooses the lock flag |
| pin_en_i | input | 1 | Lock-flag routing enable |
| pin_hold_i | input | 1 | Keep the lock flag on the pin during reads |
| rd_active_i | input | 1 | Serial read in progress |
| sdo_i | input | 1 | Serial data out |
| lock_o | output | 1 | Lock flag |
| stat_o | output | 1 | Readable lock status |
| pin_o | output | 1 | Shared output pin |

## Verification
The hardest states to reach are the long runs of 2048 and 8192 hits. Lock is only proven there if the flag stays low for one hit short of the run and rises on the last hit. The bench drives dense reference trains with short digital windows, so the 8192 run fits in about 49k cycles.

The unanswered-reference miss is also hard to reach, because it cannot arise while the window expires before the next reference. The stimulus therefore programs a 256-cycle window against a 20-cycle reference period. It then drops a single VCO pulse, so that the next reference arrives while the window is still open.

// File: rtl/pll_ld_pkg.sv
package pll_ld_pkg;
  localparam int TMR_SEL_W    = 2;
  localparam int TMR_BASE_EXP = 2;
  localparam int MULT_W       = 3;
  localparam int CNT_SEL_W    = 3;
  localparam int CNT_BASE_EXP = 6;
  localparam int PIN_SEL_W    = 5;
  localparam int PIN_LOCK_CODE = 1;

  typedef struct packed {
    logic hit;
    logic miss;
  } ld_evt_t;
endpackage

// File: rtl/ld_window_gen.sv
module ld_window_gen #(
  parameter int TMR_SEL_W    = 2,
  parameter int TMR_BASE_EXP = 2,
  parameter int MULT_W       = 3,
  localparam int WIN_W = MULT_W + (1 << TMR_SEL_W) + TMR_BASE_EXP
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 ref_pulse_i,
  input  logic [TMR_SEL_W-1:0] tmr_sel_i,
  input  logic [MULT_W-1:0]    tmr_mult_i,
  output logic                 open_o,
  output logic                 last_o
);
  logic [WIN_W-1:0] len_w;
  logic [WIN_W-1:0] rem_q;

  always_comb begin
    len_w = (WIN_W'(tmr_mult_i) + WIN_W'(1))
            << (WIN_W'(tmr_sel_i) + WIN_W'(TMR_BASE_EXP));
  end

  // rem_q counts the open cycles left after the reference cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             rem_q <= '0;
    else if (ref_pulse_i)    rem_q <= len_w - WIN_W'(1);
    else if (rem_q != '0)    rem_q <= rem_q - WIN_W'(1);
  end

  assign open_o = ref_pulse_i | (rem_q != '0);
  assign last_o = !ref_pulse_i && (rem_q == WIN_W'(1));
endmodule

// File: rtl/ld_arrival_judge.sv
module ld_arrival_judge
  import pll_ld_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    ref_pulse_i,
  input  logic    vco_pulse_i,
  input  logic    win_sel_i,
  input  logic    ext_win_i,
  input  logic    dig_open_i,
  input  logic    dig_last_i,
  output ld_evt_t evt_o
);
  logic pend_q;
  logic win_open, late_vco, expire_miss, ref_miss;

  assign win_open    = win_sel_i ? dig_open_i : ext_win_i;
  assign late_vco    = vco_pulse_i & ~win_open;
  assign expire_miss = win_sel_i & dig_last_i & pend_q & ~vco_pulse_i;
  // previous reference never answered
  assign ref_miss    = ref_pulse_i & pend_q & ~vco_pulse_i;

  assign evt_o.miss = late_vco | expire_miss | ref_miss;
  assign evt_o.hit  = vco_pulse_i & win_open;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          pend_q <= 1'b0;
    else if (ref_pulse_i) pend_q <= ~vco_pulse_i;
    else if (vco_pulse_i) pend_q <= 1'b0;
    else if (expire_miss) pend_q <= 1'b0;
  end
endmodule

// File: rtl/ld_run_counter.sv
module ld_run_counter
  import pll_ld_pkg::*;
#(
  parameter int CNT_SEL_W    = 3,
  parameter int CNT_BASE_EXP = 6,
  localparam int CNT_W = CNT_BASE_EXP + (1 << CNT_SEL_W)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  ld_evt_t              evt_i,
  input  logic [CNT_SEL_W-1:0] cnt_sel_i,
  output logic                 lock_o
);
  logic [CNT_W-1:0] need_w, cnt_q, cnt_nxt;
  logic             lock_q;

  always_comb begin
    need_w  = CNT_W'(1) << (CNT_W'(cnt_sel_i) + CNT_W'(CNT_BASE_EXP));
    cnt_nxt = cnt_q;
    if (evt_i.miss)                   cnt_nxt = '0;
    else if (evt_i.hit && cnt_q < need_w) cnt_nxt = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      lock_q <= 1'b0;
    end else begin
      cnt_q <= cnt_nxt;
      if (evt_i.miss)                          lock_q <= 1'b0;
      else if (evt_i.hit && cnt_nxt >= need_w) lock_q <= 1'b1;
    end
  end

  assign lock_o = lock_q;
endmodule

// File: rtl/ld_pin_mux.sv
module ld_pin_mux #(
  parameter int PIN_SEL_W     = 5,
  parameter int PIN_LOCK_CODE = 1
) (
  input  logic [PIN_SEL_W-1:0] pin_sel_i,
  input  logic                 pin_en_i,
  input  logic                 pin_hold_i,
  input  logic                 rd_active_i,
  input  logic                 sdo_i,
  input  logic                 lock_i,
  output logic                 pin_o
);
  logic lock_route;

  assign lock_route = (pin_sel_i == PIN_SEL_W'(PIN_LOCK_CODE)) && pin_en_i;

  always_comb begin
    if (lock_route && (pin_hold_i || !rd_active_i)) pin_o = lock_i;
    else                                            pin_o = sdo_i;
  end
endmodule

// File: rtl/pll_lock_win_det.sv
module pll_lock_win_det
  import pll_ld_pkg::*;
#(
  parameter int P_TMR_SEL_W    = TMR_SEL_W,
  parameter int P_TMR_BASE_EXP = TMR_BASE_EXP,
  parameter int P_MULT_W       = MULT_W,
  parameter int P_CNT_SEL_W    = CNT_SEL_W,
  parameter int P_CNT_BASE_EXP = CNT_BASE_EXP,
  parameter int P_PIN_SEL_W    = PIN_SEL_W,
  parameter int P_PIN_CODE     = PIN_LOCK_CODE
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   ref_pulse_i,
  input  logic                   vco_pulse_i,
  input  logic                   win_sel_i,
  input  logic                   ext_win_i,
  input  logic [P_TMR_SEL_W-1:0] tmr_sel_i,
  input  logic [P_MULT_W-1:0]    tmr_mult_i,
  input  logic [P_CNT_SEL_W-1:0] cnt_sel_i,
  input  logic [P_PIN_SEL_W-1:0] pin_sel_i,
  input  logic                   pin_en_i,
  input  logic                   pin_hold_i,
  input  logic                   rd_active_i,
  input  logic                   sdo_i,
  output logic                   lock_o,
  output logic                   stat_o,
  output logic                   pin_o
);
  logic    dig_open, dig_last, lock;
  ld_evt_t evt;

  ld_window_gen #(
    .TMR_SEL_W(P_TMR_SEL_W), .TMR_BASE_EXP(P_TMR_BASE_EXP), .MULT_W(P_MULT_W)
  ) u_win (
    .clk_i, .rst_ni, .ref_pulse_i, .tmr_sel_i, .tmr_mult_i,
    .open_o(dig_open), .last_o(dig_last)
  );

  ld_arrival_judge u_judge (
    .clk_i, .rst_ni, .ref_pulse_i, .vco_pulse_i, .win_sel_i, .ext_win_i,
    .dig_open_i(dig_open), .dig_last_i(dig_last), .evt_o(evt)
  );

  ld_run_counter #(
    .CNT_SEL_W(P_CNT_SEL_W), .CNT_BASE_EXP(P_CNT_BASE_EXP)
  ) u_cnt (
    .clk_i, .rst_ni, .evt_i(evt), .cnt_sel_i, .lock_o(lock)
  );

  ld_pin_mux #(
    .PIN_SEL_W(P_PIN_SEL_W), .PIN_LOCK_CODE(P_PIN_CODE)
  ) u_pin (
    .pin_sel_i, .pin_en_i, .pin_hold_i, .rd_active_i, .sdo_i,
    .lock_i(lock), .pin_o
  );

  assign lock_o = lock;
  assign stat_o = lock;
endmodule

// File: rtl/pll_lock_win_det_chk.sv
module pll_lock_win_det_chk
  import pll_ld_pkg::*;
(
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 lock_o,
  input logic                 pin_o,
  input logic                 sdo_i,
  input logic                 rd_active_i,
  input logic                 pin_en_i,
  input logic                 pin_hold_i,
  input logic [PIN_SEL_W-1:0] pin_sel_i,
  input logic                 win_sel_i,
  input logic                 ext_win_i,
  input logic                 vco_pulse_i,
  input ld_evt_t              evt
);
  // R4
  miss_drops_lock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt.miss |=> !lock_o);

  // R2
  lock_rise_on_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lock_o) |-> $past(evt.hit));

  // R7
  ext_outside_miss_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!win_sel_i && vco_pulse_i && !ext_win_i) |=> !lock_o);

  // R9
  pin_hold_lock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pin_sel_i == PIN_SEL_W'(PIN_LOCK_CODE) && pin_en_i && pin_hold_i) |-> pin_o == lock_o);

  // R11
  pin_sdo_route_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pin_sel_i != PIN_SEL_W'(PIN_LOCK_CODE) || !pin_en_i) |-> pin_o == sdo_i);

  // R10
  pin_read_sdo_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pin_sel_i == PIN_SEL_W'(PIN_LOCK_CODE) && pin_en_i && !pin_hold_i && rd_active_i)
      |-> pin_o == sdo_i);
endmodule

bind pll_lock_win_det pll_lock_win_det_chk u_chk (
  .clk_i, .rst_ni, .lock_o, .pin_o, .sdo_i, .rd_active_i, .pin_en_i, .pin_hold_i,
  .pin_sel_i, .win_sel_i, .ext_win_i, .vco_pulse_i, .evt
);

// File: tb/sim_pll_lock_win_det.sv
`timescale 1ns/1ps
module sim_pll_lock_win_det;
  logic clk = 0, rst_ni = 0;
  logic ref_p = 0, vco_p = 0, win_sel = 1, ext_win = 0;
  logic [1:0] tmr_sel = 0;
  logic [2:0] mult = 1, cnt_sel = 0;
  logic [4:0] pin_sel = 1;
  logic pin_en = 1, pin_hold = 1, rd_act = 0, sdo = 0;
  logic lock_o, stat_o, pin_o;

  int n_chk = 0, n_bad = 0;
  string cur_req = "R1";
  bit done = 0;

  always #5 clk = ~clk;

  pll_lock_win_det u0 (
    .clk_i(clk), .rst_ni, .ref_pulse_i(ref_p), .vco_pulse_i(vco_p),
    .win_sel_i(win_sel), .ext_win_i(ext_win), .tmr_sel_i(tmr_sel),
    .tmr_mult_i(mult), .cnt_sel_i(cnt_sel), .pin_sel_i(pin_sel),
    .pin_en_i(pin_en), .pin_hold_i(pin_hold), .rd_active_i(rd_act),
    .sdo_i(sdo), .lock_o, .stat_o, .pin_o
  );

  task automatic chk(input logic act, input logic exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int t = 0, lref = -1, lref_len = 0, cnt = 0;
  bit pend = 0, lk = 0;
  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      t = 0; lref = -1; lref_len = 0; cnt = 0; pend = 0; lk = 0;
    end else begin
      int k, len, need;
      bit dopen, wopen, expire, rmiss, miss;
      k = t - lref;
      len = (int'(mult) + 1) * (1 << (int'(tmr_sel) + 2));
      need = 1 << (int'(cnt_sel) + 6);
      dopen = ref_p || (lref >= 0 && k >= 1 && k <= lref_len - 1);
      wopen = win_sel ? dopen : ext_win;
      expire = win_sel && !ref_p && !vco_p && pend && lref >= 0 && k == lref_len - 1;
      rmiss = ref_p && pend && !vco_p;
      miss = (vco_p && !wopen) || expire || rmiss;
      if (miss) begin cnt = 0; lk = 0; end
      else if (vco_p && wopen) begin
        if (cnt < need) cnt++;
        if (cnt >= need) lk = 1;
      end
      if (ref_p) pend = !vco_p;
      else if (vco_p || expire) pend = 0;
      if (ref_p) begin lref = t; lref_len = len; end
      t++;
    end
  end

  // per-cycle comparison
  always @(negedge clk) begin
    if (rst_ni && !done) begin
      logic ep;
      chk(lock_o, lk, cur_req);
      chk(stat_o, lk, "R8");
      if (pin_sel == 5'd1 && pin_en) begin
        ep = (pin_hold || !rd_act) ? lk : sdo;
        chk(pin_o, ep, pin_hold ? "R9" : "R10");
      end else chk(pin_o, sdo, "R11");
    end
  end

  // serial side stimulus
  int sc = 0;
  always @(negedge clk) begin
    #1;
    sc++;
    sdo    <= sc[0] ^ sc[2];
    rd_act <= (sc[5:4] == 2'b11);
  end

  task automatic train(input int n, input int per, input int off, input int ext_len);
    for (int i = 0; i < n; i++)
      for (int c = 0; c < per; c++) begin
        @(negedge clk); #1;
        ref_p   = (c == 0);
        vco_p   = (off >= 0 && c == off);
        ext_win = (c < ext_len);
      end
    @(negedge clk); #1;
    ref_p = 0; vco_p = 0; ext_win = 0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #1_900_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(lock_o, 0, "R1"); chk(stat_o, 0, "R1");
    #1 rst_ni = 1;
    @(negedge clk);
    chk(lock_o, 0, "R1");

    // R2 R3: 64 hits, window 8 cycles
    cur_req = "R2"; win_sel = 1; tmr_sel = 0; mult = 1; cnt_sel = 0;
    train(63, 12, 3, 0);
    @(negedge clk); chk(lock_o, 0, "R2");
    train(1, 12, 7, 0);  // last open cycle counts (R3)
    @(negedge clk); chk(lock_o, 1, "R3");
    // R12: extra hits keep lock
    cur_req = "R12"; pin_hold = 0;
    train(80, 12, 2, 0);
    @(negedge clk); chk(lock_o, 1, "R12");

    // R4: vco just past window
    cur_req = "R4";
    train(1, 12, 8, 0);
    @(negedge clk); chk(lock_o, 0, "R4");
    // R6: relock needs full run
    cur_req = "R6";
    train(63, 12, 5, 0);
    @(negedge clk); chk(lock_o, 0, "R6");
    train(1, 12, 5, 0);
    @(negedge clk); chk(lock_o, 1, "R6");

    // R5: window expires with no vco
    cur_req = "R5"; pin_sel = 5'd2;
    train(1, 12, -1, 0);
    @(negedge clk); chk(lock_o, 0, "R5");

    // R3: longer window, 3*8 = 24 cycles
    cur_req = "R3"; tmr_sel = 1; mult = 2; pin_sel = 1; pin_en = 0;
    train(64, 30, 23, 0);
    @(negedge clk); chk(lock_o, 1, "R3");
    train(1, 30, 24, 0);
    @(negedge clk); chk(lock_o, 0, "R3");

    // R5: unanswered reference while window still open
    cur_req = "R5"; tmr_sel = 3; mult = 7; pin_en = 1; pin_hold = 1;
    train(64, 20, 2, 0);
    @(negedge clk); chk(lock_o, 1, "R5");
    train(1, 20, -1, 0);
    train(1, 20, 2, 0);
    @(negedge clk); chk(lock_o, 0, "R5");

    // R7: external window
    cur_req = "R7"; win_sel = 0;
    train(64, 10, 2, 5);
    @(negedge clk); chk(lock_o, 1, "R7");
    train(1, 10, 6, 5);
    @(negedge clk); chk(lock_o, 0, "R7");
    train(64, 10, 0, 1);
    @(negedge clk); chk(lock_o, 1, "R7");

    // R2: 2048 run
    cur_req = "R2"; win_sel = 1; tmr_sel = 0; mult = 0; cnt_sel = 5; pin_hold = 0;
    train(1, 8, -1, 0);
    train(2047, 8, 1, 0);
    @(negedge clk); chk(lock_o, 0, "R2");
    train(1, 8, 1, 0);
    @(negedge clk); chk(lock_o, 1, "R2");

    // R2: 8192 run
    cnt_sel = 7;
    train(1, 6, 5, 0);
    @(negedge clk); chk(lock_o, 0, "R4");
    train(8191, 6, 1, 0);
    @(negedge clk); chk(lock_o, 0, "R2");
    train(1, 6, 3, 0);
    @(negedge clk); chk(lock_o, 1, "R2");

    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule